// File: doc/BRIEF.md
# Data Port Read Prefetch Unit

This unit prepares the word that the next data-port read will return. While the host has a read target selected, the unit waits for a free external memory slot. A slot is free when a slot strobe arrives and the write FIFO is empty. In that slot it fetches from the selected memory into a prefetch register. When the host then reads the data port, the read completes at once if the word is ready. Otherwise the unit holds the host with a wait signal until enough slots have passed. Each completed read moves the access address forward by the auto-increment step. The next word is then fetched from the new address.

Four read targets are served. A 16-bit video RAM word is put together over two slots, one byte per slot. An 8-bit video RAM read fetches one byte. Colour RAM and vertical-scroll RAM each return one entry. For the 8-bit and colour/scroll targets, only part of the returned word comes from memory. The other bits are filled from the value of the last FIFO write. A vertical-scroll index that lies past the end of that memory is replaced by index zero. A command strobe loads a new access code and address and drops any word prepared under the old setting. A separate clear input also drops a prepared word or a half-built one.

Top module: `dport_prefetch`

## Requirements
- R1: After reset the unit holds code 4'h1 (a write code) and address 0. It does not assert `rd_wait`, `cur_addr` reads 0, and a data-port read returns 0.
- R2: A fetch takes place only in a cycle with `slot_strobe` high, `fifo_empty` high, a read target selected and no word already prepared. A slot strobe while the FIFO is not empty changes nothing. A free slot with no read pending still prepares the word ahead of time.
- R3: Code 4'h0 selects 16-bit video RAM. The first free slot places the byte at the address with bit 0 cleared into bits 15:8. The second free slot places the byte at the address with bit 0 set into bits 7:0. Only then is the word ready.
- R4: Code 4'hC selects 8-bit video RAM. One free slot places the byte at the address with bit 0 inverted into bits 7:0. Bits 15:8 come from `fifo_last`.
- R5: Code 4'h8 selects colour RAM at entry address[6:1], which is the word address modulo 64. Result bits under mask 16'h0EEE come from that entry. All other bits come from `fifo_last`.
- R6: Code 4'h4 selects vertical-scroll RAM. The index is address[6:1]. An index of 40 or more is replaced by 0. Bits under mask 16'h07FF come from the entry, and bits under 16'hF800 come from `fifo_last`.
- R7: Any other code counts as a write. A read under such a code returns 0 in the same cycle, never asserts `rd_wait` and leaves the address unchanged.
- R8: A read in a cycle where the word is ready returns the prepared word in that cycle. From the next cycle the address is the old address plus `auto_inc`, modulo 2^16. The following fetch uses that new address.
- R9: `rd_wait` is high in every cycle where `rd_req` is high, a read target is selected and the word is not yet ready.
- R10: `cmd_wr` loads `cmd_code` and `cmd_addr`. It discards both the prepared word and a half-built 16-bit word. `pf_clear` discards both as well. After either one, a read needs the full number of slots again.
- R11: A prepared word does not change when `fifo_last` changes after the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Load a new access code and address |
| cmd_code | input | 4 | Access code to load |
| cmd_addr | input | 16 | Access address to load |
| pf_clear | input | 1 | Discard prepared and half-built words |
| auto_inc | input | 8 | Address step applied after each read |
| slot_strobe | input | 1 | External memory slot available this cycle |
| fifo_empty | input | 1 | Write FIFO holds no pending entry |
| fifo_last | input | 16 | Value of the most recent FIFO write |
| vram_addr | output | 16 | Video RAM byte read address |
| vram_data | input | 8 | Video RAM read byte (same cycle) |
| cram_addr | output | 6 | Colour RAM read index |
| cram_data | input | 16 | Colour RAM read entry (same cycle) |
| vsram_addr | output | 6 | Vertical-scroll RAM read index |
| vsram_data | input | 16 | Vertical-scroll RAM read entry (same cycle) |
| rd_req | input | 1 | Host data-port read, held until `rd_wait` is low |
| rd_wait | output | 1 | Host must keep holding the read |
| rd_data | output | 16 | Data-port read value |
| cur_addr | output | 16 | Current access address |

## Verification
`rd_wait` and `rd_data` follow `rd_req` in the same cycle, with no register between them. A fetch made in a slot becomes visible just after that slot's rising edge. A completed read moves `cur_addr` forward at the rising edge that ends the read cycle. The bench drives every input just after a falling edge and samples the outputs 1 ns later or at the next falling edge. Each result is therefore read in the half-cycle after the edge that produces it. Slot counts are measured by driving exactly one strobe per cycle while `rd_wait` stays high.

// File: rtl/dprf_pkg.sv
`timescale 1ns/1ps
package dprf_pkg;

   localparam int CODE_W = 4;

   typedef enum logic [2:0] {
      TGT_NONE   = 3'd0,
      TGT_VRAM16 = 3'd1,
      TGT_VRAM8  = 3'd2,
      TGT_CRAM   = 3'd3,
      TGT_VSRAM  = 3'd4
   } tgt_e;

   // Map an access code to a read target; every other code acts as a write.
   function automatic tgt_e decode_tgt(input logic [CODE_W-1:0] code);
      tgt_e t;
      unique case (code)
         4'h0:    t = TGT_VRAM16;
         4'hC:    t = TGT_VRAM8;
         4'h8:    t = TGT_CRAM;
         4'h4:    t = TGT_VSRAM;
         default: t = TGT_NONE;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/dprf_index_map.sv
`timescale 1ns/1ps
module dprf_index_map
   import dprf_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int CRAM_DEPTH  = 64,
   parameter int VSRAM_DEPTH = 40,
   parameter int VS_SPAN     = 64
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic                           half,
   input  tgt_e                           tgt,
   output logic [ADDR_W-1:0]              vram_addr,
   output logic [$clog2(CRAM_DEPTH)-1:0]  cram_idx,
   output logic [$clog2(VSRAM_DEPTH)-1:0] vsram_idx
);
   localparam int CRAM_IW   = $clog2(CRAM_DEPTH);
   localparam int VSRAM_IW  = $clog2(VSRAM_DEPTH);
   localparam int VS_SPAN_W = $clog2(VS_SPAN);
   localparam logic [VS_SPAN_W:0] VS_LIMIT = (VS_SPAN_W+1)'(VSRAM_DEPTH);

   // Byte selection: second half of a wide word, swapped byte, or even byte.
   always_comb begin
      if (half)
         vram_addr = {addr[ADDR_W-1:1], 1'b1};
      else if (tgt == TGT_VRAM8)
         vram_addr = {addr[ADDR_W-1:1], ~addr[0]};
      else
         vram_addr = {addr[ADDR_W-1:1], 1'b0};
   end

   generate
      if (CRAM_DEPTH == (1 << CRAM_IW)) begin : g_cram_slice
         assign cram_idx = addr[CRAM_IW:1];
      end else begin : g_cram_mod
         assign cram_idx = CRAM_IW'(addr[ADDR_W-1:1] % CRAM_DEPTH);
      end
   endgenerate

   logic [VS_SPAN_W-1:0] vs_span_idx;
   logic [VS_SPAN_W-1:0] vs_clamped;

   assign vs_span_idx = addr[VS_SPAN_W:1];
   assign vs_clamped  = ({1'b0, vs_span_idx} >= VS_LIMIT) ? '0 : vs_span_idx;

   generate
      if (VSRAM_IW == VS_SPAN_W) begin : g_vs_same
         assign vsram_idx = vs_clamped;
      end else begin : g_vs_narrow
         assign vsram_idx = VSRAM_IW'(vs_clamped);
      end
   endgenerate

endmodule

// File: rtl/dprf_merge.sv
`timescale 1ns/1ps
module dprf_merge
   import dprf_pkg::*;
#(
   parameter int                DATA_W     = 16,
   parameter logic [DATA_W-1:0] CRAM_MASK  = 16'h0EEE,
   parameter logic [DATA_W-1:0] VSRAM_MASK = 16'h07FF
) (
   input  tgt_e                  tgt,
   input  logic                  half,
   input  logic [DATA_W-1:0]     pf_q,
   input  logic [DATA_W/2-1:0]   vram_data,
   input  logic [DATA_W-1:0]     cram_data,
   input  logic [DATA_W-1:0]     vsram_data,
   input  logic [DATA_W-1:0]     fifo_last,
   output logic [DATA_W-1:0]     next_val
);
   localparam int BYTE_W = DATA_W / 2;
   localparam logic [DATA_W-1:0] HI_MASK = {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};

   always_comb begin
      unique case (tgt)
         TGT_VRAM16:
            next_val = half ? (pf_q | {{BYTE_W{1'b0}}, vram_data})
                            : {vram_data, {BYTE_W{1'b0}}};
         TGT_VRAM8:
            next_val = (fifo_last & HI_MASK) | {{BYTE_W{1'b0}}, vram_data};
         TGT_CRAM:
            next_val = (cram_data & CRAM_MASK) | (fifo_last & ~CRAM_MASK);
         TGT_VSRAM:
            next_val = (vsram_data & VSRAM_MASK) | (fifo_last & ~VSRAM_MASK);
         default:
            next_val = pf_q;
      endcase
   end

endmodule

// File: rtl/dport_prefetch.sv
`timescale 1ns/1ps
module dport_prefetch
   import dprf_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 16,
   parameter int                INC_W       = 8,
   parameter int                CRAM_DEPTH  = 64,
   parameter int                VSRAM_DEPTH = 40,
   parameter int                VS_SPAN     = 64,
   parameter logic [DATA_W-1:0] CRAM_MASK   = 16'h0EEE,
   parameter logic [DATA_W-1:0] VSRAM_MASK  = 16'h07FF
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cmd_wr,
   input  logic [3:0]                     cmd_code,
   input  logic [ADDR_W-1:0]              cmd_addr,
   input  logic                           pf_clear,
   input  logic [INC_W-1:0]               auto_inc,
   input  logic                           slot_strobe,
   input  logic                           fifo_empty,
   input  logic [DATA_W-1:0]              fifo_last,
   output logic [ADDR_W-1:0]              vram_addr,
   input  logic [DATA_W/2-1:0]            vram_data,
   output logic [$clog2(CRAM_DEPTH)-1:0]  cram_addr,
   input  logic [DATA_W-1:0]              cram_data,
   output logic [$clog2(VSRAM_DEPTH)-1:0] vsram_addr,
   input  logic [DATA_W-1:0]              vsram_data,
   input  logic                           rd_req,
   output logic                           rd_wait,
   output logic [DATA_W-1:0]              rd_data,
   output logic [ADDR_W-1:0]              cur_addr
);
   localparam int VS_SPAN_W = $clog2(VS_SPAN);
   localparam logic [CODE_W-1:0] RESET_CODE = 4'h1;

   generate
      if (DATA_W % 2 != 0)          begin : g_bad_data  $error("DATA_W must be even");            end
      if (INC_W > ADDR_W)           begin : g_bad_inc   $error("INC_W exceeds ADDR_W");           end
      if (VSRAM_DEPTH > VS_SPAN)    begin : g_bad_vs    $error("VSRAM_DEPTH exceeds VS_SPAN");    end
      if (VS_SPAN_W + 1 > ADDR_W)   begin : g_bad_span  $error("VS_SPAN too wide for ADDR_W");    end
      if ($clog2(CRAM_DEPTH) + 1 > ADDR_W) begin : g_bad_cram $error("CRAM_DEPTH too large");   end
   endgenerate

   logic [CODE_W-1:0] code_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] pf_q;
   logic              fetched_q;
   logic              half_q;

   tgt_e              tgt;
   logic              is_rd;
   logic              fetch_go;
   logic              rd_done;
   logic [DATA_W-1:0] next_val;

   assign tgt      = decode_tgt(code_q);
   assign is_rd    = (tgt != TGT_NONE);
   assign fetch_go = slot_strobe & fifo_empty & is_rd & ~fetched_q & ~cmd_wr & ~pf_clear;
   assign rd_done  = rd_req & is_rd & fetched_q & ~cmd_wr;

   dprf_index_map #(
      .ADDR_W      (ADDR_W),
      .CRAM_DEPTH  (CRAM_DEPTH),
      .VSRAM_DEPTH (VSRAM_DEPTH),
      .VS_SPAN     (VS_SPAN)
   ) u_map (
      .addr      (addr_q),
      .half      (half_q),
      .tgt       (tgt),
      .vram_addr (vram_addr),
      .cram_idx  (cram_addr),
      .vsram_idx (vsram_addr)
   );

   dprf_merge #(
      .DATA_W     (DATA_W),
      .CRAM_MASK  (CRAM_MASK),
      .VSRAM_MASK (VSRAM_MASK)
   ) u_merge (
      .tgt        (tgt),
      .half       (half_q),
      .pf_q       (pf_q),
      .vram_data  (vram_data),
      .cram_data  (cram_data),
      .vsram_data (vsram_data),
      .fifo_last  (fifo_last),
      .next_val   (next_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q    <= RESET_CODE;
         addr_q    <= '0;
         pf_q      <= '0;
         fetched_q <= 1'b0;
         half_q    <= 1'b0;
      end else if (cmd_wr) begin
         code_q    <= cmd_code;
         addr_q    <= cmd_addr;
         fetched_q <= 1'b0;
         half_q    <= 1'b0;
      end else begin
         if (rd_done) begin
            addr_q    <= addr_q + ADDR_W'(auto_inc);
            fetched_q <= 1'b0;
         end
         if (fetch_go) begin
            pf_q <= next_val;
            if (tgt == TGT_VRAM16 && !half_q) begin
               half_q <= 1'b1;
            end else begin
               half_q    <= 1'b0;
               fetched_q <= 1'b1;
            end
         end
         if (pf_clear) begin
            fetched_q <= 1'b0;
            half_q    <= 1'b0;
         end
      end
   end

   assign rd_wait  = rd_req & is_rd & ~fetched_q;
   assign rd_data  = (is_rd & fetched_q) ? pf_q : '0;
   assign cur_addr = addr_q;

endmodule

// File: rtl/dport_prefetch_chk.sv
`timescale 1ns/1ps
module dport_prefetch_chk
   import dprf_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int INC_W       = 8,
   parameter int VSRAM_DEPTH = 40
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           cmd_wr,
   input logic                           pf_clear,
   input logic                           slot_strobe,
   input logic                           fifo_empty,
   input logic                           rd_req,
   input logic                           rd_wait,
   input logic [DATA_W-1:0]              rd_data,
   input logic [ADDR_W-1:0]              cur_addr,
   input logic [INC_W-1:0]               auto_inc,
   input logic [CODE_W-1:0]              code_q,
   input logic                           fetched_q,
   input logic                           half_q,
   input logic [$clog2(VSRAM_DEPTH)-1:0] vsram_addr
);
   logic chk_rd;
   assign chk_rd = (decode_tgt(code_q) != TGT_NONE);

   // R2: a word only becomes ready after a free slot
   a_r2_fetch_in_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetched_q) |-> $past(slot_strobe && fifo_empty));

   // R3: a half-built word and a ready word never coexist
   a_r3_half_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetched_q && half_q));

   // R6: scroll index never leaves the memory
   a_r6_vs_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(vsram_addr) < VSRAM_DEPTH);

   // R7: write codes read zero without waiting
   a_r7_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !chk_rd) |-> (!rd_wait && rd_data == '0));

   // R7: write codes do not move the address
   a_r7_write_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !chk_rd && !cmd_wr) |=> (cur_addr == $past(cur_addr)));

   // R8: a completed read steps the address and consumes the word
   a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && chk_rd && !rd_wait && !cmd_wr) |=>
         (cur_addr == $past(cur_addr + ADDR_W'(auto_inc)) && !fetched_q));

   // R10: command load or clear drops any partial or ready word
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr || pf_clear) |=> (!fetched_q && !half_q));

   // R11: a ready word holds while it is not consumed
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fetched_q && !rd_req && !cmd_wr && !pf_clear) |=> $stable(rd_data));

endmodule

bind dport_prefetch dport_prefetch_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .INC_W       (INC_W),
   .VSRAM_DEPTH (VSRAM_DEPTH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_wr      (cmd_wr),
   .pf_clear    (pf_clear),
   .slot_strobe (slot_strobe),
   .fifo_empty  (fifo_empty),
   .rd_req      (rd_req),
   .rd_wait     (rd_wait),
   .rd_data     (rd_data),
   .cur_addr    (cur_addr),
   .auto_inc    (auto_inc),
   .code_q      (code_q),
   .fetched_q   (fetched_q),
   .half_q      (half_q),
   .vsram_addr  (vsram_addr)
);

// File: tb/dport_prefetch_bench.sv
`timescale 1ns/1ps
module dport_prefetch_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [3:0]  cmd_code = 4'h0;
   logic [15:0] cmd_addr = 16'h0;
   logic        pf_clear = 1'b0;
   logic [7:0]  auto_inc = 8'h2;
   logic        slot_strobe = 1'b0;
   logic        fifo_empty = 1'b1;
   logic [15:0] fifo_last = 16'h0;
   logic [15:0] vram_addr;
   logic [7:0]  vram_data;
   logic [5:0]  cram_addr;
   logic [15:0] cram_data;
   logic [5:0]  vsram_addr;
   logic [15:0] vsram_data;
   logic        rd_req = 1'b0;
   logic        rd_wait;
   logic [15:0] rd_data;
   logic [15:0] cur_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [7:0] vram_f(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction
   function automatic logic [15:0] cram_f(input logic [5:0] i);
      return {4'hF, i, i};
   endfunction
   function automatic logic [15:0] vsram_f(input logic [5:0] i);
      return {i, i, i[3:0]} ^ 16'h5A3C;
   endfunction

   assign vram_data  = vram_f(vram_addr);
   assign cram_data  = cram_f(cram_addr);
   assign vsram_data = vsram_f(vsram_addr);

   function automatic logic [15:0] exp_val(input logic [3:0] c, input logic [15:0] a,
                                           input logic [15:0] fl);
      logic [5:0] idx;
      case (c)
         4'h0: return {vram_f({a[15:1], 1'b0}), vram_f({a[15:1], 1'b1})};
         4'hC: return {fl[15:8], vram_f({a[15:1], ~a[0]})};
         4'h8: return (cram_f(a[6:1]) & 16'h0EEE) | (fl & ~16'h0EEE);
         4'h4: begin
            idx = a[6:1];
            if (idx >= 6'd40) idx = 6'd0;
            return (vsram_f(idx) & 16'h07FF) | (fl & 16'hF800);
         end
         default: return 16'h0;
      endcase
   endfunction

   function automatic int slots_for(input logic [3:0] c);
      case (c)
         4'h0: return 2;
         4'hC, 4'h8, 4'h4: return 1;
         default: return 0;
      endcase
   endfunction

   dport_prefetch u_dport_prefetch (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
      .pf_clear(pf_clear), .auto_inc(auto_inc), .slot_strobe(slot_strobe),
      .fifo_empty(fifo_empty), .fifo_last(fifo_last), .vram_addr(vram_addr),
      .vram_data(vram_data), .cram_addr(cram_addr), .cram_data(cram_data),
      .vsram_addr(vsram_addr), .vsram_data(vsram_data), .rd_req(rd_req),
      .rd_wait(rd_wait), .rd_data(rd_data), .cur_addr(cur_addr)
   );

   task automatic ck(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cmd(input logic [3:0] c, input logic [15:0] a);
      cmd_wr = 1'b1; cmd_code = c; cmd_addr = a;
      step();
      cmd_wr = 1'b0;
      #1;
   endtask

   // Read with one slot per waiting cycle; checks wait count, value and address step.
   task automatic do_read(input string tag, input logic [15:0] exp, input int exp_slots,
                          input bit steps);
      int n;
      logic [15:0] a0;
      n = 0;
      a0 = cur_addr;
      rd_req = 1'b1;
      #1;
      ck(rd_wait == (exp_slots > 0), {"R9 wait at request ", tag}, 32'(rd_wait), 32'(exp_slots > 0));
      while (rd_wait && n < 8) begin
         slot_strobe = 1'b1;
         step();
         slot_strobe = 1'b0;
         #1;
         n++;
      end
      ck(n == exp_slots, {tag, " slot count"}, 32'(n), 32'(exp_slots));
      ck(rd_data == exp, {tag, " data"}, 32'(rd_data), 32'(exp));
      step();
      rd_req = 1'b0;
      #1;
      ck(cur_addr == (steps ? a0 + 16'(auto_inc) : a0), {"R8 address step ", tag},
         32'(cur_addr), 32'(steps ? a0 + 16'(auto_inc) : a0));
   endtask

   // Sequential reads of one target from a start address.
   task automatic sweep(input string tag, input logic [3:0] c, input logic [15:0] a,
                        input logic [7:0] inc, input int count, input bit vary_fl);
      logic [15:0] m_addr;
      auto_inc = inc;
      cmd(c, a);
      m_addr = a;
      for (int i = 0; i < count; i++) begin
         if (vary_fl) fifo_last = 16'(i * 16'h1F3B + 16'h0951);
         #1;
         do_read(tag, exp_val(c, m_addr, fifo_last), slots_for(c), slots_for(c) > 0);
         m_addr = m_addr + 16'(inc);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1: reset state
      ck(rd_wait == 1'b0, "R1 rd_wait after reset", 32'(rd_wait), 0);
      ck(cur_addr == 16'h0, "R1 cur_addr after reset", 32'(cur_addr), 0);
      do_read("R1 reset read", 16'h0, 0, 1'b0);

      // R3 / R8: wide video RAM, even and odd starts
      fifo_last = 16'hC3C3;
      sweep("R3 vram16 even", 4'h0, 16'h1230, 8'd2, 12, 1'b0);
      sweep("R3 vram16 odd",  4'h0, 16'h4567, 8'd3, 10, 1'b0);
      sweep("R8 vram16 wrap", 4'h0, 16'hFFFC, 8'd2, 4, 1'b0);

      // R4: byte video RAM with varying FIFO value
      sweep("R4 vram8", 4'hC, 16'h2001, 8'd1, 12, 1'b1);

      // R5: colour RAM, beyond 64 entries to cover wrap
      fifo_last = 16'hF3C5;
      sweep("R5 cram", 4'h8, 16'h0000, 8'd2, 70, 1'b0);
      sweep("R5 cram vary", 4'h8, 16'h0301, 8'd6, 12, 1'b1);

      // R6: scroll RAM across all 64 indexes, including the clamped ones
      fifo_last = 16'hA5A5;
      sweep("R6 vsram", 4'h4, 16'h0000, 8'd2, 64, 1'b0);
      sweep("R6 vsram vary", 4'h4, 16'h0150, 8'd2, 8, 1'b1);

      // R7: write and unknown codes
      auto_inc = 8'd2;
      cmd(4'h1, 16'h0100);
      do_read("R7 write code", 16'h0, 0, 1'b0);
      cmd(4'h2, 16'h0200);
      do_read("R7 other code", 16'h0, 0, 1'b0);
      cmd(4'h5, 16'h0300);
      do_read("R7 write code 5", 16'h0, 0, 1'b0);

      // R2: a slot while the FIFO holds data is ignored
      fifo_last = 16'h7700;
      cmd(4'hC, 16'h0040);
      rd_req = 1'b1; fifo_empty = 1'b0; slot_strobe = 1'b1;
      step();
      slot_strobe = 1'b0;
      #1;
      ck(rd_wait == 1'b1, "R2 busy FIFO slot ignored", 32'(rd_wait), 1);
      rd_req = 1'b0; fifo_empty = 1'b1;
      #1;
      do_read("R2 after FIFO drains", exp_val(4'hC, 16'h0040, 16'h7700), 1, 1'b1);

      // R2: free slot without a pending read prepares ahead
      cmd(4'h8, 16'h0020);
      slot_strobe = 1'b1;
      step();
      slot_strobe = 1'b0;
      #1;
      do_read("R2 ahead prefetch", exp_val(4'h8, 16'h0020, 16'h7700), 0, 1'b1);

      // R10: clear in the middle of a wide word
      cmd(4'h0, 16'h3456);
      slot_strobe = 1'b1;
      step();
      slot_strobe = 1'b0;
      pf_clear = 1'b1;
      step();
      pf_clear = 1'b0;
      #1;
      do_read("R10 clear half word", exp_val(4'h0, 16'h3456, 16'h7700), 2, 1'b1);

      // R10: clear a ready word
      cmd(4'hC, 16'h0777);
      slot_strobe = 1'b1;
      step();
      slot_strobe = 1'b0;
      pf_clear = 1'b1;
      step();
      pf_clear = 1'b0;
      #1;
      do_read("R10 clear ready word", exp_val(4'hC, 16'h0777, 16'h7700), 1, 1'b1);

      // R10: new command replaces a ready word
      cmd(4'h4, 16'h0010);
      slot_strobe = 1'b1;
      step();
      slot_strobe = 1'b0;
      cmd(4'hC, 16'h5A5B);
      ck(cur_addr == 16'h5A5B, "R10 command loads address", 32'(cur_addr), 32'h5A5B);
      do_read("R10 command reload", exp_val(4'hC, 16'h5A5B, 16'h7700), 1, 1'b1);

      // R11: FIFO value changes after the fetch do not alter the word
      fifo_last = 16'h1200;
      cmd(4'hC, 16'h0600);
      slot_strobe = 1'b1;
      step();
      slot_strobe = 1'b0;
      fifo_last = 16'h3400;
      step();
      #1;
      do_read("R11 held word", exp_val(4'hC, 16'h0600, 16'h1200), 0, 1'b1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule